// File: doc/BRIEF.md
# Fieldbus Manchester Frame Transmitter

This block turns one outgoing fieldbus frame into a Manchester-coded line signal at 31.25 kbit/s. It does not run on a clock of its own. It advances only on a base tick that arrives at 500 kHz, and it spends a fixed number of ticks on each half of a symbol. Payload bytes come in one at a time through a single holding register, which a processor or a DMA source refills when the register reports that it is empty. The line carries, in this order, a selectable number of preamble octets, a start delimiter, the payload, an optional frame check sequence, and an end delimiter.

A frame starts when the send enable is high and the holding register holds a byte. At the start of each payload byte the byte moves from the holding register into the shifter, and the register then reports empty. If the register is still empty when a byte ends, the payload is over. The block then sends the check sequence (when it is enabled) and the end delimiter, and returns to idle.

Top module: `mtx_frame_tx`

## Requirements
- R1: After reset `frame_idle` = 1, `buf_empty` = 1, `tx_active` = 0 and `tx_line` = 0.
- R2: A pulse on `wr_strobe` stores `wr_data` and makes `buf_empty` 0 from the next clock. While `send_enable` is 0 no frame starts: `tx_active` stays 0 and the byte stays held, so `buf_empty` remains 0.
- R3: A frame starts when `send_enable` = 1 and `buf_empty` = 0. `tx_active` is 1 and `frame_idle` is 0 for every cycle from the first symbol through the last end-delimiter symbol. Both return to their idle values after that symbol.
- R4: Each symbol lasts 2×HALF_TICKS base ticks, split into two halves of HALF_TICKS ticks each. Data 1 is sent high then low and data 0 is sent low then high. The non-data symbol N+ is high in both halves and N- is low in both halves. The line is low while idle.
- R5: `preamble_len` codes 0, 1, 2 and 3 give 1, 2, 3 and 4 preamble octets. Each preamble octet is 0x55, sent MSB first.
- R6: The start delimiter is the 8-symbol sequence 1, N+, N-, 1, 0, N-, N+, 0.
- R7: Payload bytes are sent MSB first. A byte leaves the holding register when its first bit begins, and `buf_empty` goes to 1 at that point.
- R8: If `buf_empty` = 1 when the last bit of a payload byte ends, the payload stops there. No further data bits are sent.
- R9: With `crc_append` = 1 the payload is followed by 16 bits, sent MSB first. They are the ones' complement of a CRC-16 with polynomial 0x1021 and preset 0xFFFF, computed over the payload bits MSB first. With `crc_append` = 0 these 16 bits are left out.
- R10: The end delimiter is the 8-symbol sequence 1, N+, N-, N+, N-, 1, 0, 1.
- R11: The line changes only on cycles where `base_tick` = 1. The same frame results whatever the spacing of the ticks.
- R12: `preamble_len` and `crc_append` are captured when the frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | 500 kHz clock enable |
| send_enable | input | 1 | Allows a frame to start |
| crc_append | input | 1 | Append the check sequence |
| preamble_len | input | 2 | Preamble octet count minus one |
| wr_strobe | input | 1 | Load the holding register |
| wr_data | input | 8 | Byte to load |
| buf_empty | output | 1 | Holding register has no byte |
| frame_idle | output | 1 | No frame in progress |
| tx_active | output | 1 | Transmitter drive enable |
| tx_line | output | 1 | Manchester-coded line level |

## Verification
The bench builds the block with HALF_TICKS = 2, so a symbol takes four ticks and a full frame takes a few hundred cycles. That short frame length lets the bench run every combination of preamble code, check-sequence enable and payload length from one to three bytes. Each captured line is compared half-symbol by half-symbol against a frame that the bench assembles itself, with the CRC computed by arithmetic in the bench. Extra frames use sparse ticks, change the captured settings during a frame, and hold a byte while sending is disabled.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

   localparam int OCT_W = 8;

   typedef enum logic [1:0] {
      SYM_ZERO = 2'b00,
      SYM_ONE  = 2'b01,
      SYM_HIGH = 2'b10,
      SYM_LOW  = 2'b11
   } sym_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SD,
      ST_DATA,
      ST_FCS,
      ST_ED
   } phase_t;

   // two bits per symbol, first symbol in the top pair
   localparam logic [15:0] OPEN_MARK  = 16'b01_10_11_01_00_11_10_00;
   localparam logic [15:0] CLOSE_MARK = 16'b01_10_11_10_11_01_00_01;

   function automatic sym_t mark_sym(input logic [15:0] pat, input logic [2:0] idx);
      logic [15:0] s;
      s = pat << {idx, 1'b0};
      return sym_t'(s[15:14]);
   endfunction

   function automatic logic sym_level(input sym_t s, input logic late);
      case (s)
         SYM_ZERO: return late;
         SYM_ONE:  return ~late;
         SYM_HIGH: return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/mtx_half_timer.sv
module mtx_half_timer #(
   parameter int HALF_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic late_half,
   output logic sym_end
);
   localparam int SYM_TICKS = 2 * HALF_TICKS;
   localparam int CNT_W     = (SYM_TICKS > 1) ? $clog2(SYM_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_TICKS - 1);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(HALF_TICKS);

   generate
      if (HALF_TICKS < 1) begin : g_bad_half
         $error("HALF_TICKS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] tcnt_q;
   logic [CNT_W-1:0] tcnt_inc;

   generate
      if ((SYM_TICKS & (SYM_TICKS - 1)) == 0) begin : g_wrap_pow2
         assign tcnt_inc = tcnt_q + 1'b1;
      end else begin : g_wrap_cmp
         assign tcnt_inc = (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tcnt_q <= '0;
      else if (restart) tcnt_q <= '0;
      else if (tick)    tcnt_q <= tcnt_inc;
   end

   assign late_half = (tcnt_q >= MID);
   assign sym_end   = tick && !restart && (tcnt_q == LAST);

   p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(tcnt_q));
   p_symbol_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sym_end |=> (tcnt_q == '0) && !late_half);

endmodule

// File: rtl/mtx_crc_serial.sv
module mtx_crc_serial #(
   parameter int              CRC_W      = 16,
   parameter logic [CRC_W-1:0] CRC_POLY   = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_PRESET = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic absorb,
   input  logic din,
   input  logic drain,
   output logic msb
);
   generate
      if (CRC_W < 2) begin : g_bad_width
         $error("CRC_W must be at least 2");
      end
   endgenerate

   logic [CRC_W-1:0] crc_q;
   logic             fb;

   assign fb = crc_q[CRC_W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= CRC_PRESET;
      else if (init)   crc_q <= CRC_PRESET;
      else if (absorb) crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      else if (drain)  crc_q <= {crc_q[CRC_W-2:0], 1'b0};
   end

   assign msb = crc_q[CRC_W-1];

   p_preset_on_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (crc_q == CRC_PRESET));
   p_no_mix_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(absorb && drain));

endmodule

// File: rtl/mtx_byte_hold.sv
module mtx_byte_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data,
   output logic              empty
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         empty <= 1'b1;
      end else begin
         if (wr)        data <= wr_data;
         if (wr)        empty <= 1'b0;
         else if (take) empty <= 1'b1;
      end
   end

   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !empty);
   p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr) |=> empty);
   p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(data));

endmodule

// File: rtl/mtx_frame_tx.sv
module mtx_frame_tx
   import mtx_pkg::*;
#(
   parameter int               HALF_TICKS     = 8,
   parameter int               PRE_SEL_W      = 2,
   parameter int               CRC_W          = 16,
   parameter logic [CRC_W-1:0] CRC_POLY       = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_PRESET     = '1,
   parameter logic [7:0]       PREAMBLE_OCTET = 8'h55
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 base_tick,
   input  logic                 send_enable,
   input  logic                 crc_append,
   input  logic [PRE_SEL_W-1:0] preamble_len,
   input  logic                 wr_strobe,
   input  logic [7:0]           wr_data,
   output logic                 buf_empty,
   output logic                 frame_idle,
   output logic                 tx_active,
   output logic                 tx_line
);
   localparam int IDX_W = (CRC_W > OCT_W) ? $clog2(CRC_W) : $clog2(OCT_W);
   localparam logic [IDX_W-1:0] OCT_LAST = IDX_W'(OCT_W - 1);
   localparam logic [IDX_W-1:0] FCS_LAST = IDX_W'(CRC_W - 1);

   generate
      if (PRE_SEL_W < 1) begin : g_bad_pre
         $error("PRE_SEL_W must be positive");
      end
   endgenerate

   phase_t               state_q;
   logic [IDX_W-1:0]     idx_q;
   logic [PRE_SEL_W-1:0] pre_cnt_q;
   logic [PRE_SEL_W-1:0] pre_sel_q;
   logic                 fcs_q;
   logic [OCT_W-1:0]     shreg_q;

   logic [OCT_W-1:0] hold_data;
   logic             hold_empty;
   logic             late_half;
   logic             sym_end;
   logic             crc_msb;
   logic             start_go;
   logic             last_oct;
   logic             last_fcs;
   logic             take;
   logic             crc_init;
   logic             crc_absorb;
   logic             crc_drain;
   logic [2:0]       pre_bit;
   sym_t             cur_sym;

   assign last_oct   = (idx_q == OCT_LAST);
   assign last_fcs   = (idx_q == FCS_LAST);
   assign start_go   = (state_q == ST_IDLE) && send_enable && !hold_empty;
   assign crc_init   = sym_end && (state_q == ST_SD) && last_oct;
   assign take       = crc_init ||
                       (sym_end && (state_q == ST_DATA) && last_oct && !hold_empty);
   assign crc_absorb = sym_end && (state_q == ST_DATA);
   assign crc_drain  = sym_end && (state_q == ST_FCS);

   mtx_byte_hold #(.DATA_W(OCT_W)) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_strobe),
      .wr_data (wr_data),
      .take    (take),
      .data    (hold_data),
      .empty   (hold_empty)
   );

   mtx_half_timer #(.HALF_TICKS(HALF_TICKS)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (base_tick),
      .restart   (start_go),
      .late_half (late_half),
      .sym_end   (sym_end)
   );

   mtx_crc_serial #(
      .CRC_W      (CRC_W),
      .CRC_POLY   (CRC_POLY),
      .CRC_PRESET (CRC_PRESET)
   ) crc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (crc_init),
      .absorb (crc_absorb),
      .din    (shreg_q[OCT_W-1]),
      .drain  (crc_drain),
      .msb    (crc_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         idx_q     <= '0;
         pre_cnt_q <= '0;
         pre_sel_q <= '0;
         fcs_q     <= 1'b0;
         shreg_q   <= '0;
      end else if (start_go) begin
         state_q   <= ST_PRE;
         idx_q     <= '0;
         pre_cnt_q <= '0;
         pre_sel_q <= preamble_len;
         fcs_q     <= crc_append;
      end else if (sym_end) begin
         case (state_q)
            ST_PRE: begin
               if (last_oct) begin
                  idx_q <= '0;
                  if (pre_cnt_q == pre_sel_q) state_q <= ST_SD;
                  else                        pre_cnt_q <= pre_cnt_q + 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_SD: begin
               if (last_oct) begin
                  idx_q   <= '0;
                  state_q <= ST_DATA;
                  shreg_q <= hold_data;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_DATA: begin
               if (last_oct) begin
                  idx_q <= '0;
                  if (!hold_empty) shreg_q <= hold_data;
                  else             state_q <= fcs_q ? ST_FCS : ST_ED;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  shreg_q <= {shreg_q[OCT_W-2:0], 1'b0};
               end
            end
            ST_FCS: begin
               if (last_fcs) begin
                  idx_q   <= '0;
                  state_q <= ST_ED;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_ED: begin
               if (last_oct) begin
                  idx_q   <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: begin
               idx_q   <= '0;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign pre_bit = 3'd7 - idx_q[2:0];

   always_comb begin
      case (state_q)
         ST_PRE:  cur_sym = PREAMBLE_OCTET[pre_bit] ? SYM_ONE : SYM_ZERO;
         ST_SD:   cur_sym = mark_sym(OPEN_MARK, idx_q[2:0]);
         ST_DATA: cur_sym = shreg_q[OCT_W-1] ? SYM_ONE : SYM_ZERO;
         ST_FCS:  cur_sym = crc_msb ? SYM_ZERO : SYM_ONE;
         ST_ED:   cur_sym = mark_sym(CLOSE_MARK, idx_q[2:0]);
         default: cur_sym = SYM_LOW;
      endcase
   end

   assign buf_empty  = hold_empty;
   assign frame_idle = (state_q == ST_IDLE);
   assign tx_active  = (state_q != ST_IDLE);
   assign tx_line    = tx_active && sym_level(cur_sym, late_half);

   p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && !send_enable) |=> frame_idle);
   p_preamble_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRE) |-> (pre_cnt_q <= pre_sel_q));
   p_ends_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_DATA) && sym_end && last_oct && hold_empty) |=> (state_q != ST_DATA));
   p_fcs_skipped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_DATA) && sym_end && last_oct && hold_empty && !fcs_q) |=> (state_q == ST_ED));
   p_close_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_ED) && sym_end && last_oct) |=> (frame_idle && !tx_line));
   p_settings_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && !start_go) |=> ($stable(pre_sel_q) && $stable(fcs_q)));

endmodule

// File: tb/mtx_frame_tx_tb_top.sv
module mtx_frame_tx_tb_top;
   localparam int H   = 2;
   localparam int CAP = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       send_enable = 1'b0;
   logic       crc_append = 1'b0;
   logic [1:0] preamble_len = 2'd0;
   logic       wr_strobe = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       buf_empty, frame_idle, tx_active, tx_line;

   always #2 clk = ~clk;

   mtx_frame_tx #(.HALF_TICKS(H)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_tick    (base_tick),
      .send_enable  (send_enable),
      .crc_append   (crc_append),
      .preamble_len (preamble_len),
      .wr_strobe    (wr_strobe),
      .wr_data      (wr_data),
      .buf_empty    (buf_empty),
      .frame_idle   (frame_idle),
      .tx_active    (tx_active),
      .tx_line      (tx_line)
   );

   int checks = 0;
   int errors = 0;
   bit exp_lv [0:CAP-1];
   bit cap_lv [0:CAP-1];
   int exp_n = 0;
   int cap_n = 0;
   int seg_start [0:4];
   int seg_len   [0:4];
   logic [7:0] fb [0:7];
   int fb_n = 0;
   int fb_i = 0;
   bit feed_on = 1'b0;
   int tick_div = 1;
   int tick_ph = 0;
   int flag_bad = 0;

   int open_sym  [0:7] = '{1, 2, 3, 1, 0, 3, 2, 0};
   int close_sym [0:7] = '{1, 2, 3, 2, 3, 1, 0, 1};

   always @(negedge clk) begin
      wr_strobe = 1'b0;
      if (rst_n && feed_on && buf_empty && (fb_i < fb_n)) begin
         wr_strobe = 1'b1;
         wr_data   = fb[fb_i];
         fb_i++;
      end
      tick_ph++;
      if (tick_ph >= tick_div) tick_ph = 0;
      base_tick = (tick_ph == 0);
      if (rst_n && (tx_active == frame_idle)) flag_bad++;
      if (tx_active && base_tick && (cap_n < CAP)) begin
         cap_lv[cap_n] = tx_line;
         cap_n++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit lvl(input int s, input bit late);
      case (s)
         0: return late;
         1: return !late;
         2: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic push_sym(input int s);
      for (int half = 0; half < 2; half++)
         for (int k = 0; k < H; k++) begin
            exp_lv[exp_n] = lvl(s, half[0]);
            exp_n++;
         end
   endtask

   task automatic push_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) push_sym(b[i] ? 1 : 0);
   endtask

   task automatic build(input int pre, input bit fcs, input int n);
      logic [15:0] crc;
      bit f;
      exp_n = 0;
      seg_start[0] = 0;
      for (int o = 0; o <= pre; o++) push_byte(8'h55);
      seg_len[0] = exp_n;
      seg_start[1] = exp_n;
      for (int i = 0; i < 8; i++) push_sym(open_sym[i]);
      seg_len[1] = exp_n - seg_start[1];
      seg_start[2] = exp_n;
      crc = 16'hFFFF;
      for (int j = 0; j < n; j++) begin
         push_byte(fb[j]);
         for (int i = 7; i >= 0; i--) begin
            f   = crc[15] ^ fb[j][i];
            crc = {crc[14:0], 1'b0};
            if (f) crc = crc ^ 16'h1021;
         end
      end
      seg_len[2] = exp_n - seg_start[2];
      seg_start[3] = exp_n;
      if (fcs)
         for (int i = 15; i >= 0; i--) push_sym(crc[i] ? 0 : 1);
      seg_len[3] = exp_n - seg_start[3];
      seg_start[4] = exp_n;
      for (int i = 0; i < 8; i++) push_sym(close_sym[i]);
      seg_len[4] = exp_n - seg_start[4];
   endtask

   task automatic compare_seg(input int si, input string req, inout int total);
      int bad = 0;
      int first = -1;
      for (int i = seg_start[si]; i < seg_start[si] + seg_len[si]; i++)
         if (i >= cap_n || cap_lv[i] != exp_lv[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      total += bad;
      check(bad == 0, req, $sformatf("segment %0d mismatching samples (first at %0d)", si, first),
            bad, 0);
   endtask

   task automatic run_frame(input int pre, input bit fcs, input int n, input int seed,
                            input bit hold, input bit flip, input string tag);
      int total = 0;
      int shape_bad = 0;
      @(negedge clk);
      preamble_len = pre[1:0];
      crc_append   = fcs;
      for (int k = 0; k < n; k++) fb[k] = 8'((seed * 73 + k * 29 + 5) ^ (k * 8'hA6));
      fb_i = 0;
      fb_n = n;
      cap_n = 0;
      flag_bad = 0;
      build(pre, fcs, n);
      feed_on = 1'b1;
      while (buf_empty) @(negedge clk);
      if (hold) begin
         repeat (20) @(negedge clk);
         check(!tx_active && !buf_empty, "R2", "held byte with sending disabled (active,empty)",
               {tx_active, buf_empty}, 0);
      end
      send_enable = 1'b1;
      while (!tx_active) @(negedge clk);
      send_enable = 1'b0;
      if (flip) begin
         preamble_len = ~pre[1:0];
         crc_append   = !fcs;
      end
      while (tx_active) @(negedge clk);
      repeat (3) @(negedge clk);
      feed_on = 1'b0;
      check(cap_n == exp_n, "R8", "frame length in ticks", cap_n, exp_n);
      compare_seg(0, "R5", total);
      compare_seg(1, "R6", total);
      compare_seg(2, "R7", total);
      compare_seg(3, "R9", total);
      compare_seg(4, "R10", total);
      for (int s = seg_start[2]; s < seg_start[2] + seg_len[2]; s += 2 * H)
         for (int k = 0; k < H; k++)
            if (cap_lv[s + k] != cap_lv[s] || cap_lv[s + H + k] == cap_lv[s]) shape_bad++;
      check(shape_bad == 0, "R4", "data symbol shape errors", shape_bad, 0);
      check(flag_bad == 0, "R3", "cycles with tx_active equal to frame_idle", flag_bad, 0);
      check(frame_idle && buf_empty && !tx_line, "R3", "idle, empty and low line after frame",
            {frame_idle, buf_empty, tx_line}, 3'b110);
      if (tag != "") begin
         check(total == 0, tag, "whole-frame sample mismatches", total, 0);
         check(cap_n == exp_n, tag, "whole-frame length", cap_n, exp_n);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(frame_idle && buf_empty && !tx_active && !tx_line, "R1",
            "reset state idle,empty,active,line",
            {frame_idle, buf_empty, tx_active, tx_line}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(frame_idle && buf_empty && !tx_line, "R1", "state after reset release",
            {frame_idle, buf_empty, tx_line}, 3'b110);
      for (int p = 0; p < 4; p++)
         for (int f = 0; f < 2; f++)
            for (int n = 1; n <= 3; n++)
               run_frame(p, f[0], n, p * 6 + f * 3 + n, (p == 0 && f == 0 && n == 1), 1'b0, "");
      tick_div = 3;
      run_frame(1, 1'b1, 2, 40, 1'b0, 1'b0, "R11");
      tick_div = 1;
      run_frame(0, 1'b1, 2, 41, 1'b0, 1'b1, "R12");
      run_frame(2, 1'b0, 1, 42, 1'b0, 1'b1, "R12");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule